// File: doc/BRIEF.md
# DLL Lock Command Gating Timer

This block sits beside a DDR memory controller and watches the command bus that the controller drives. It keeps a model of the memory's delay-locked loop (DLL): whether the loop is on, whether the device is in self refresh, and how many clocks have passed since the loop was last switched on. From that model it raises two registered permission outputs. One tells the controller that a read may be issued. The other tells it that any other command may be issued. Any command that breaks a timing or state rule produces a one-cycle violation pulse and sets a sticky error bit.

The DLL can be switched on in two ways, and each way sets its own wait for non-read commands. An extended mode write that enables the loop blocks non-read commands for a short mode-set delay. Leaving self refresh blocks them for a longer exit delay. Both ways restart a long lock count before reads are allowed. The block only observes the bus. It applies no back-pressure: the ready outputs are advisory, the command bus has no handshake, and a command issued while its ready is low still takes effect and is flagged.

The last settings written by an extended mode write are held and brought out. They stay until the next extended mode write or until reset, which stands in for power loss.

Top module: `dll_gate_timer`

## Requirements
- R1: A command with `cmd_valid`=1, `cmd_op`=3'd1 (mode set) and `cmd_ba`=2'b01 (bit0 is BA0=1, bit1 is BA1=0) is an extended mode write. It loads `cmd_addr[1]` into `cfg_drive_weak` and `cmd_addr[2]` into `cfg_aux_en` on that edge. A mode set with any other `cmd_ba` value changes neither output nor `dll_on`.
- R2: In an extended mode write, `cmd_addr[0]`=0 switches the DLL on and `cmd_addr[0]`=1 switches it off. `dll_on` shows the new state after that edge.
- R3: An extended mode write issued while `all_banks_idle`=0 raises `viol_pulse` in the following cycle.
- R4: After a DLL-on event at edge E (an extended mode write enabling the DLL, or a self-refresh exit), `rd_ready` is 0 through edge E+198 and is 1 after edge E+199. A read is therefore first legal at edge E+200. A new DLL-on event while this count runs restarts it, and `rd_ready` drops at once.
- R5: After any extended mode write at edge E, `nrd_ready` is 0 after E and 1 after E+1, so a non-read command is first legal at edge E+2.
- R6: A self-refresh entry (`cmd_op`=3'd3) sets `dll_on`, `rd_ready` and `nrd_ready` to 0 until the exit. A self-refresh exit (`cmd_op`=3'd4) at edge E while in self refresh sets `dll_on` to 1. It keeps `nrd_ready` at 0 through E+8 and sets it to 1 after E+9, and it restarts the read lock count of R4.
- R7: While the DLL is switched off by an extended mode write, `rd_ready` stays 0 however long the wait, and a read (`cmd_op`=3'd2) raises `viol_pulse`.
- R8: In the cycle after the command, `viol_pulse` is 1 for exactly one cycle if any of these holds: a read was issued while `rd_ready`=0; a command other than a read or a self-refresh exit (op codes 0, 1, 3, 5 to 7) was issued while `nrd_ready`=0; or a self-refresh exit was issued outside self refresh. A self-refresh exit outside self refresh has no other effect. A legal command leaves `viol_pulse` at 0.
- R9: `viol_sticky` is set by every violation and cleared by `err_clear`=1. When a clear and a violation fall on the same edge, the bit stays set.
- R10: While `rst_n`=0, `dll_on`, `rd_ready`, `nrd_ready`, `cfg_drive_weak`, `cfg_aux_en`, `viol_pulse` and `viol_sticky` are 0. `nrd_ready` rises after the first edge following the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset (power loss) |
| cmd_valid | input | 1 | A command is on the bus this cycle |
| cmd_op | input | 3 | Command class: 0 other, 1 mode set, 2 read, 3 self-refresh entry, 4 self-refresh exit, 5-7 other |
| cmd_ba | input | 2 | Bank address of the command (bit0 BA0, bit1 BA1) |
| cmd_addr | input | 3 | Low address bits carried by a mode set |
| all_banks_idle | input | 1 | All banks are precharged |
| err_clear | input | 1 | Clears the sticky error bit |
| dll_on | output | 1 | Modelled DLL state |
| cfg_drive_weak | output | 1 | Stored drive-strength setting |
| cfg_aux_en | output | 1 | Stored auxiliary output-isolation enable |
| rd_ready | output | 1 | A read may be issued this cycle |
| nrd_ready | output | 1 | A non-read command may be issued this cycle |
| viol_pulse | output | 1 | One-cycle flag for an illegal command |
| viol_sticky | output | 1 | Sticky error bit |

## Verification
The lock timing is tested with both DLL-on sources. An enabling extended mode write is followed by a check of the short non-read wait. A self-refresh exit is followed by a check of the long non-read wait, which proves that the limit follows the source. In each case the read permission is sampled one cycle before and one cycle after its edge. Back-to-back command patterns are used to separate the rules: an early read with a legal non-read next to it, an early non-read, and commands during self refresh. A mode set on the wrong bank address and a self-refresh exit outside self refresh are each checked to produce no state change. A write while banks are busy and a clear that meets a new violation show that the sticky bit gives priority to setting.

// File: rtl/dll_gate_pkg.sv
`timescale 1ns/1ps
package dll_gate_pkg;

  typedef enum logic [2:0] {
    OP_OTHER    = 3'd0,
    OP_MODESET  = 3'd1,
    OP_READ     = 3'd2,
    OP_SR_ENTER = 3'd3,
    OP_SR_EXIT  = 3'd4
  } cmd_op_e;

  // bank-address value that selects the extended mode register (BA1=0, BA0=1)
  localparam logic [1:0] EXT_BANK_SEL = 2'b01;

  typedef struct packed {
    logic ext_write;   // extended mode write
    logic read;
    logic sr_enter;
    logic sr_exit;
    logic gated_nonread; // subject to the non-read wait
  } cmd_class_t;

  typedef struct packed {
    logic aux_en;
    logic drive_weak;
    logic dll_off;
  } ext_cfg_t;

endpackage

// File: rtl/dll_cmd_decode.sv
`timescale 1ns/1ps
module dll_cmd_decode
  import dll_gate_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [1:0]       cmd_ba,
  output cmd_class_t       cls
);

  logic is_read, is_exit;

  always_comb begin
    is_read           = (cmd_op == OP_READ);
    is_exit           = (cmd_op == OP_SR_EXIT);
    cls.ext_write     = cmd_valid && (cmd_op == OP_MODESET) && (cmd_ba == EXT_BANK_SEL);
    cls.read          = cmd_valid && is_read;
    cls.sr_enter      = cmd_valid && (cmd_op == OP_SR_ENTER);
    cls.sr_exit       = cmd_valid && is_exit;
    cls.gated_nonread = cmd_valid && !is_read && !is_exit;
  end

endmodule

// File: rtl/dll_wait_timer.sv
`timescale 1ns/1ps
module dll_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  input  logic             gate,
  output logic             ready_q,
  output logic [CNT_W-1:0] count_q
);

  logic [CNT_W-1:0] count_d;
  logic             ready_d;

  always_comb begin
    if (restart)              count_d = '0;
    else if (count_q < limit) count_d = count_q + 1'b1;
    else                      count_d = count_q;
    // ready one cycle before the limit so the command at the limit edge is legal
    ready_d = gate && (count_d >= limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ready_q <= 1'b0;
    end else begin
      count_q <= count_d;
      ready_q <= ready_d;
    end
  end

  // R4: the count never jumps by more than one unless restarted
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

  // R4: a restart withdraws permission at once when the wait exceeds one cycle
  assert_restart_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && limit > 1) |=> !ready_q);

endmodule

// File: rtl/dll_rule_check.sv
`timescale 1ns/1ps
module dll_rule_check
  import dll_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_class_t cls,
  input  logic       rd_ready,
  input  logic       nrd_ready,
  input  logic       in_sr,
  input  logic       all_banks_idle,
  input  logic       err_clear,
  output logic       viol_pulse,
  output logic       viol_sticky
);

  logic illegal;

  always_comb begin
    illegal = (cls.read          && !rd_ready)  ||
              (cls.gated_nonread && !nrd_ready) ||
              (cls.sr_exit       && !in_sr)     ||
              (cls.ext_write     && !all_banks_idle);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_pulse  <= 1'b0;
      viol_sticky <= 1'b0;
    end else begin
      viol_pulse  <= illegal;
      viol_sticky <= (viol_sticky && !err_clear) || illegal;
    end
  end

  // R9: every pulse is mirrored in the sticky bit
  assert_pulse_sets_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_sticky);

  // R3: extended mode write with a busy bank is flagged
  assert_busy_write_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls.ext_write && !all_banks_idle) |=> viol_pulse);

  // R9: without a clear the sticky bit never falls
  assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_sticky && !err_clear) |=> viol_sticky);

endmodule

// File: rtl/dll_gate_timer.sv
`timescale 1ns/1ps
module dll_gate_timer
  import dll_gate_pkg::*;
#(
  parameter int RD_LOCK_CYC = 200,
  parameter int MRD_CYC     = 2,
  parameter int XSNR_CYC    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [1:0] cmd_ba,
  input  logic [2:0] cmd_addr,
  input  logic       all_banks_idle,
  input  logic       err_clear,
  output logic       dll_on,
  output logic       cfg_drive_weak,
  output logic       cfg_aux_en,
  output logic       rd_ready,
  output logic       nrd_ready,
  output logic       viol_pulse,
  output logic       viol_sticky
);

  localparam int RD_W   = $clog2(RD_LOCK_CYC + 1);
  localparam int NR_MAX = (XSNR_CYC > MRD_CYC) ? XSNR_CYC : MRD_CYC;
  localparam int NR_W   = $clog2(NR_MAX + 1);
  localparam logic [RD_W-1:0] RD_LIM  = RD_W'(RD_LOCK_CYC);
  localparam logic [NR_W-1:0] MRD_LIM = NR_W'(MRD_CYC);
  localparam logic [NR_W-1:0] XSN_LIM = NR_W'(XSNR_CYC);

  cmd_class_t cls;
  ext_cfg_t   cfg_q, cfg_d;
  logic       dll_on_q, dll_on_d;
  logic       in_sr_q, in_sr_d;
  logic [NR_W-1:0] nr_lim_q, nr_lim_d;
  logic       dll_en_evt, dll_dis_evt, sre_evt, srx_evt;
  logic       rd_restart, nr_restart, rd_gate, nr_gate;
  logic [RD_W-1:0] rd_count;
  logic [NR_W-1:0] nr_count;

  dll_cmd_decode u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ba    (cmd_ba),
    .cls       (cls)
  );

  always_comb begin
    dll_en_evt  = cls.ext_write && !cmd_addr[0];
    dll_dis_evt = cls.ext_write &&  cmd_addr[0];
    sre_evt     = cls.sr_enter;
    srx_evt     = cls.sr_exit && in_sr_q;

    in_sr_d = in_sr_q;
    if (sre_evt)      in_sr_d = 1'b1;
    else if (srx_evt) in_sr_d = 1'b0;

    dll_on_d = dll_on_q;
    if (sre_evt)          dll_on_d = 1'b0;
    else if (srx_evt)     dll_on_d = 1'b1;
    else if (dll_en_evt)  dll_on_d = 1'b1;
    else if (dll_dis_evt) dll_on_d = 1'b0;

    cfg_d = cfg_q;
    if (cls.ext_write) cfg_d = ext_cfg_t'(cmd_addr);

    nr_lim_d = nr_lim_q;
    if (srx_evt)            nr_lim_d = XSN_LIM;
    else if (cls.ext_write) nr_lim_d = MRD_LIM;

    rd_restart = dll_en_evt || srx_evt;
    nr_restart = cls.ext_write || srx_evt;
    rd_gate    = dll_on_d && !in_sr_d;
    nr_gate    = !in_sr_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll_on_q <= 1'b0;
      in_sr_q  <= 1'b0;
      cfg_q    <= '0;
      nr_lim_q <= MRD_LIM;
    end else begin
      dll_on_q <= dll_on_d;
      in_sr_q  <= in_sr_d;
      cfg_q    <= cfg_d;
      nr_lim_q <= nr_lim_d;
    end
  end

  dll_wait_timer #(.CNT_W(RD_W)) u_rd_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rd_restart),
    .limit   (RD_LIM),
    .gate    (rd_gate),
    .ready_q (rd_ready),
    .count_q (rd_count)
  );

  dll_wait_timer #(.CNT_W(NR_W)) u_nr_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (nr_restart),
    .limit   (nr_lim_d),
    .gate    (nr_gate),
    .ready_q (nrd_ready),
    .count_q (nr_count)
  );

  dll_rule_check u_rules (
    .clk            (clk),
    .rst_n          (rst_n),
    .cls            (cls),
    .rd_ready       (rd_ready),
    .nrd_ready      (nrd_ready),
    .in_sr          (in_sr_q),
    .all_banks_idle (all_banks_idle),
    .err_clear      (err_clear),
    .viol_pulse     (viol_pulse),
    .viol_sticky    (viol_sticky)
  );

  assign dll_on         = dll_on_q;
  assign cfg_drive_weak = cfg_q.drive_weak;
  assign cfg_aux_en     = cfg_q.aux_en;

  // R7: read permission requires a running DLL
  assert_rd_needs_dll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> dll_on_q);

  // R6: nothing but an exit is permitted inside self refresh
  assert_sr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr_q |-> (!rd_ready && !nrd_ready));

  // R6: self-refresh entry always turns the DLL off
  assert_sre_drops_dll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sre_evt |=> !dll_on_q);

  // R1: stored settings move only on an extended mode write
  assert_cfg_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cls.ext_write |=> $stable(cfg_q));

  // R4: read permission implies the lock count has nearly finished
  assert_rd_after_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (rd_count >= RD_LIM - 1'b1));

  // R5: non-read permission implies the selected wait has nearly elapsed
  assert_nr_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nrd_ready |-> (nr_count >= nr_lim_q - 1'b1));

endmodule

// File: tb/tb_dll_gate_timer.sv
`timescale 1ns/1ps
module tb_dll_gate_timer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_ba = 2'b00;
  logic [2:0] cmd_addr = 3'b000;
  logic all_banks_idle = 1'b1;
  logic err_clear = 1'b0;
  logic dll_on, cfg_drive_weak, cfg_aux_en, rd_ready, nrd_ready, viol_pulse, viol_sticky;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dll_gate_timer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .all_banks_idle(all_banks_idle),
    .err_clear(err_clear), .dll_on(dll_on), .cfg_drive_weak(cfg_drive_weak),
    .cfg_aux_en(cfg_aux_en), .rd_ready(rd_ready), .nrd_ready(nrd_ready),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic issue(input logic [2:0] op, input logic [1:0] ba, input logic [2:0] addr,
                       input logic idle, input logic exp_viol, input string tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_ba = ba; cmd_addr = addr; all_banks_idle = idle;
    @(posedge clk);
    exp_q.push_back(exp_viol);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_ba = 2'b00; cmd_addr = 3'b000; all_banks_idle = 1'b1;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard on the violation pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, viol_pulse, e);
      end else if (viol_pulse) begin
        chk("R8 stray pulse", viol_pulse, 1'b0);
      end
    end
  end

  initial begin
    idle_cycles(3);
    chk("R10 reset dll_on", dll_on, 1'b0);
    chk("R10 reset rd_ready", rd_ready, 1'b0);
    chk("R10 reset nrd_ready", nrd_ready, 1'b0);
    chk("R10 reset cfg", cfg_drive_weak | cfg_aux_en, 1'b0);
    chk("R10 reset viol", viol_pulse | viol_sticky, 1'b0);
    rst_n = 1'b1;
    chk("R10 nrd before first edge", nrd_ready, 1'b0);
    idle_cycles(1);
    chk("R10 nrd after first edge", nrd_ready, 1'b1);

    // enable via extended write, drive weak, aux on
    issue(3'd1, 2'b01, 3'b110, 1'b1, 1'b0, "R1 enable write legal");
    chk("R2 dll_on after enable", dll_on, 1'b1);
    chk("R1 drive field", cfg_drive_weak, 1'b1);
    chk("R1 aux field", cfg_aux_en, 1'b1);
    chk("R5 nrd low after write", nrd_ready, 1'b0);
    idle_cycles(1);
    chk("R5 nrd high at E+1", nrd_ready, 1'b1);
    idle_cycles(197);
    chk("R4 rd low at E+198", rd_ready, 1'b0);
    idle_cycles(1);
    chk("R4 rd high at E+199", rd_ready, 1'b1);
    issue(3'd2, 2'b00, 3'b000, 1'b1, 1'b0, "R8 legal read");

    // plain mode sets on other bank addresses are not extended writes
    issue(3'd1, 2'b00, 3'b001, 1'b1, 1'b0, "R1 mode set ba00 legal");
    chk("R1 ba00 keeps dll", dll_on, 1'b1);
    chk("R1 ba00 keeps drive", cfg_drive_weak, 1'b1);
    issue(3'd1, 2'b11, 3'b001, 1'b1, 1'b0, "R1 mode set ba11 legal");
    chk("R1 ba11 keeps dll", dll_on, 1'b1);
    chk("R1 ba11 keeps aux", cfg_aux_en, 1'b1);
    chk("R1 ba11 keeps rd_ready", rd_ready, 1'b1);

    // write with busy bank, then early read and boundary non-read
    issue(3'd1, 2'b01, 3'b000, 1'b0, 1'b1, "R3 write with busy bank");
    chk("R4 restart drops rd_ready", rd_ready, 1'b0);
    chk("R1 drive cleared", cfg_drive_weak, 1'b0);
    issue(3'd2, 2'b00, 3'b000, 1'b1, 1'b1, "R8 early read");
    issue(3'd0, 2'b00, 3'b000, 1'b1, 1'b0, "R5 non-read at E+2 legal");
    issue(3'd1, 2'b01, 3'b000, 1'b1, 1'b0, "R5 write after wait legal");
    issue(3'd0, 2'b00, 3'b000, 1'b1, 1'b1, "R5 non-read at E+1 illegal");
    idle_cycles(200);
    chk("R4 rd ready after restart", rd_ready, 1'b1);

    // sticky behaviour
    chk("R9 sticky set", viol_sticky, 1'b1);
    err_clear = 1'b1;
    idle_cycles(1);
    err_clear = 1'b0;
    chk("R9 sticky cleared", viol_sticky, 1'b0);
    err_clear = 1'b1;
    issue(3'd4, 2'b00, 3'b000, 1'b1, 1'b1, "R8 exit outside self refresh");
    err_clear = 1'b0;
    chk("R9 set wins over clear", viol_sticky, 1'b1);
    chk("R8 stray exit keeps dll", dll_on, 1'b1);
    chk("R8 stray exit keeps rd_ready", rd_ready, 1'b1);
    err_clear = 1'b1;
    idle_cycles(1);
    err_clear = 1'b0;

    // self refresh
    issue(3'd3, 2'b00, 3'b000, 1'b1, 1'b0, "R6 entry legal");
    chk("R6 entry dll off", dll_on, 1'b0);
    chk("R6 entry rd low", rd_ready, 1'b0);
    chk("R6 entry nrd low", nrd_ready, 1'b0);
    issue(3'd0, 2'b00, 3'b000, 1'b1, 1'b1, "R8 non-read in self refresh");
    issue(3'd2, 2'b00, 3'b000, 1'b1, 1'b1, "R8 read in self refresh");
    issue(3'd4, 2'b00, 3'b000, 1'b1, 1'b0, "R6 exit legal");
    chk("R6 exit dll on", dll_on, 1'b1);
    idle_cycles(8);
    chk("R6 nrd low at E+8", nrd_ready, 1'b0);
    idle_cycles(1);
    chk("R6 nrd high at E+9", nrd_ready, 1'b1);
    idle_cycles(189);
    chk("R6 rd low at E+198", rd_ready, 1'b0);
    idle_cycles(1);
    chk("R6 rd high at E+199", rd_ready, 1'b1);

    // disable by extended write
    issue(3'd1, 2'b01, 3'b001, 1'b1, 1'b0, "R2 disable write legal");
    chk("R2 dll off", dll_on, 1'b0);
    chk("R7 rd low after disable", rd_ready, 1'b0);
    idle_cycles(250);
    chk("R7 rd stays low", rd_ready, 1'b0);
    chk("R7 nrd available", nrd_ready, 1'b1);
    issue(3'd2, 2'b00, 3'b000, 1'b1, 1'b1, "R7 read with dll off");
    idle_cycles(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule